// File: doc/BRIEF.md
# DMA Channel Service Arbiter with One-Level Preemption

This block decides which DMA channel the transfer engine serves next. Each channel raises a request line while it wants service. The engine reports the end of every minor-loop iteration with a one-cycle done pulse. Along with that pulse it gives a per-channel flag saying whether the iteration just finished was the last one of the channel's major loop. The arbiter registers the chosen channel and a grant-valid flag. It also keeps one active flag per channel, which stays set from the first grant of a major loop until its final iteration completes.

There are two arbitration modes. In fixed-priority mode each channel has a programmable priority level. A running channel that is marked as interruptible can be suspended part-way through an iteration when a strictly more urgent channel asks for service. The urgent channel then runs exactly one minor iteration, and the suspended channel takes the grant back. During the suspension both channels show an active flag. In round-robin mode the priority levels have no effect, the grant rotates over the requesters, and no suspension ever happens.

Top module: `dma_chan_arb`

## Requirements
- R1: After reset, grant_vld_o is 0, active_o is all zeros and the round-robin pointer is 0.
- R2: In fixed mode (rr_mode_i = 0), the channel chosen among requesters is the one with the largest priority value, where channel i's priority is prio_i[i*PRIO_W +: PRIO_W]. On a tie, the lower channel index wins.
- R3: In round-robin mode (rr_mode_i = 1), priorities are ignored. The chosen channel is the first requester found when scanning upward from the pointer and wrapping at NCH. The pointer then becomes the granted index plus one, modulo NCH.
- R4: A new channel is chosen only when the arbiter is idle or done_i is high while busy. A request that arrives mid-iteration without the preemption condition leaves the grant unchanged, and done_i while idle has no effect on active_o.
- R5: In fixed mode, suppose the running channel has its pre_en_i bit set, nothing is suspended, and another channel with a strictly larger priority requests while done_i is low. Then on the next edge the grant moves to that channel, and both it and the suspended channel read 1 in active_o.
- R6: On done_i from a preempting channel, the grant returns to the suspended channel on the next edge, whatever else is requesting.
- R7: While a channel is suspended, no further preemption occurs: an even more urgent request does not change the grant until the current iteration ends.
- R8: No preemption occurs in round-robin mode, or when the running channel's pre_en_i bit is 0.
- R9: A channel's active flag is set when it is granted and is cleared on a done_i pulse while it is granted with its final_i bit set. A done_i with final_i clear leaves the flag set.
- R10: Granted output outputs are registered: grant_ch_o and grant_vld_o change only on the clock edge after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NCH | Per-channel service request |
| prio_i | input | NCH*PRIO_W | Packed per-channel priority, larger is more urgent |
| pre_en_i | input | NCH | Per-channel permission to be suspended |
| rr_mode_i | input | 1 | 1 selects round-robin, 0 fixed priority |
| done_i | input | 1 | Engine finished one minor iteration of the granted channel |
| final_i | input | NCH | Per-channel flag: the current iteration is the last of the major loop |
| grant_ch_o | output | $clog2(NCH) | Channel currently granted |
| grant_vld_o | output | 1 | A channel is granted |
| active_o | output | NCH | Per-channel major loop in progress |

## Verification
The hardest state to reach is a chain of events in fixed mode. An interruptible channel is suspended, and a third, even more urgent channel requests while the preempting channel is still running. After the resume, that waiting channel then suspends the resumed channel in turn. The stimulus reaches this by holding a low-priority channel granted and raising two higher requests on consecutive mid-iteration cycles, with done_i held low. It then pulses done_i with only the preempting channel's final flag set, and watches the grant for two more cycles. Separate directed runs cover the same mid-iteration request with the permission bit cleared and in round-robin mode. Exhaustive sweeps over every request pattern and every priority assignment of a four-channel configuration cover plain selection in both modes.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_ROUND = 1'b1
    } arb_mode_e;
endpackage

// File: rtl/dma_arb_prio_pick.sv
module dma_arb_prio_pick #(
    parameter int NCH    = 16,
    parameter int PRIO_W = 4,
    parameter int CH_W   = 4
) (
    input  logic [NCH-1:0]        req,
    input  logic [NCH*PRIO_W-1:0] prio,
    output logic                  found,
    output logic [CH_W-1:0]       idx,
    output logic [PRIO_W-1:0]     best
);
    // Strictly-greater replacement keeps the lowest index on ties.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (req[i] && (!found || prio[i*PRIO_W +: PRIO_W] > best)) begin
                found = 1'b1;
                idx   = CH_W'(i);
                best  = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
    parameter int NCH  = 16,
    parameter int CH_W = 4
) (
    input  logic [NCH-1:0]  req,
    input  logic [CH_W-1:0] ptr,
    output logic            found,
    output logic [CH_W-1:0] idx
);
    int j;
    always_comb begin
        found = 1'b0;
        idx   = '0;
        j     = 0;
        for (int k = 0; k < NCH; k++) begin
            j = (int'(ptr) + k) % NCH;
            if (!found && req[j]) begin
                found = 1'b1;
                idx   = CH_W'(j);
            end
        end
    end
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb
    import dma_arb_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int PRIO_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         req_i,
    input  logic [NCH*PRIO_W-1:0]  prio_i,
    input  logic [NCH-1:0]         pre_en_i,
    input  logic                   rr_mode_i,
    input  logic                   done_i,
    input  logic [NCH-1:0]         final_i,
    output logic [$clog2(NCH)-1:0] grant_ch_o,
    output logic                   grant_vld_o,
    output logic [NCH-1:0]         active_o
);
    localparam int CH_W = $clog2(NCH);

    typedef struct packed {
        logic            busy;
        logic [CH_W-1:0] cur;
        logic            susp_vld;
        logic [CH_W-1:0] susp;
        logic [NCH-1:0]  active;
        logic [CH_W-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    arb_mode_e mode;
    assign mode = arb_mode_e'(rr_mode_i);

    // Candidate selection: fixed over all requesters, fixed over others
    // (for preemption), and rotating.
    logic              fx_found, pre_found, rr_found;
    logic [CH_W-1:0]   fx_idx, pre_idx, rr_idx;
    logic [PRIO_W-1:0] fx_best, pre_best;
    logic [NCH-1:0]    others;

    assign others = req_i & ~(NCH'(1) << st_q.cur);

    dma_arb_prio_pick #(.NCH(NCH), .PRIO_W(PRIO_W), .CH_W(CH_W)) u_fix_all (
        .req(req_i), .prio(prio_i), .found(fx_found), .idx(fx_idx), .best(fx_best)
    );

    dma_arb_prio_pick #(.NCH(NCH), .PRIO_W(PRIO_W), .CH_W(CH_W)) u_fix_pre (
        .req(others), .prio(prio_i), .found(pre_found), .idx(pre_idx), .best(pre_best)
    );

    dma_arb_rr_pick #(.NCH(NCH), .CH_W(CH_W)) u_rr (
        .req(req_i), .ptr(st_q.ptr), .found(rr_found), .idx(rr_idx)
    );

    logic [PRIO_W-1:0] cur_prio;
    logic              preempt, win_found, arb_pt, resume;
    logic [CH_W-1:0]   win_idx;

    assign cur_prio  = prio_i[st_q.cur*PRIO_W +: PRIO_W];
    assign preempt   = st_q.busy && !done_i && (mode == ARB_FIXED) &&
                       pre_en_i[st_q.cur] && !st_q.susp_vld &&
                       pre_found && (pre_best > cur_prio);
    assign resume    = st_q.busy && done_i && st_q.susp_vld;
    assign arb_pt    = !st_q.busy || done_i;
    assign win_found = (mode == ARB_ROUND) ? rr_found : fx_found;
    assign win_idx   = (mode == ARB_ROUND) ? rr_idx   : fx_idx;

    always_comb begin
        st_d = st_q;
        if (st_q.busy && done_i && final_i[st_q.cur]) begin
            st_d.active[st_q.cur] = 1'b0;
        end
        if (preempt) begin
            st_d.susp_vld        = 1'b1;
            st_d.susp            = st_q.cur;
            st_d.cur             = pre_idx;
            st_d.active[pre_idx] = 1'b1;
        end else if (resume) begin
            st_d.cur      = st_q.susp;
            st_d.susp_vld = 1'b0;
            st_d.busy     = 1'b1;
        end else if (arb_pt) begin
            st_d.busy = win_found;
            if (win_found) begin
                st_d.cur             = win_idx;
                st_d.active[win_idx] = 1'b1;
                if (mode == ARB_ROUND) begin
                    st_d.ptr = (win_idx == CH_W'(NCH-1)) ? '0 : CH_W'(win_idx + 1'b1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_ch_o  = st_q.cur;
    assign grant_vld_o = st_q.busy;
    assign active_o    = st_q.active;

    AST_GRANT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.active[st_q.cur]); // R9
    AST_SUSP_BOTH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.susp_vld |-> (st_q.busy && st_q.active[st_q.susp] && st_q.susp != st_q.cur)); // R5
    AST_RESUME_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.susp_vld && done_i) |=> (grant_vld_o && grant_ch_o == $past(st_q.susp))); // R6
    AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.susp_vld && !done_i) |=> (st_q.susp_vld && $stable(st_q.susp) && $stable(grant_ch_o))); // R7
    AST_RR_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !done_i && rr_mode_i) |=> (grant_vld_o && $stable(grant_ch_o))); // R8
    AST_NO_PREEMPT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !done_i && !pre_en_i[st_q.cur]) |=> $stable(grant_ch_o)); // R8
endmodule

// File: tb/sim_dma_chan_arb.sv
module sim_dma_chan_arb;
    localparam int NCH = 4;
    localparam int PW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NCH-1:0] req = '0, pre_en = '0, fin = '0;
    logic [NCH*PW-1:0] prio = '0;
    logic          rr = 1'b0, done = 1'b0;
    logic [1:0]    g_ch;
    logic          g_vld;
    logic [NCH-1:0] act;

    int n_chk = 0, n_bad = 0;
    int rr_ptr = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    dma_chan_arb #(.NCH(NCH), .PRIO_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio), .pre_en_i(pre_en),
        .rr_mode_i(rr), .done_i(done), .final_i(fin),
        .grant_ch_o(g_ch), .grant_vld_o(g_vld), .active_o(act)
    );

    task automatic chk(input string tag, input int actv, input int expv);
        n_chk++;
        if (actv != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, actv, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic int fixed_pick(input logic [NCH-1:0] r, input logic [NCH*PW-1:0] p);
        int best = -1, bi = -1;
        for (int i = 0; i < NCH; i++) begin
            if (r[i] && int'(p[i*PW +: PW]) > best) begin
                best = int'(p[i*PW +: PW]);
                bi = i;
            end
        end
        return bi;
    endfunction

    function automatic int rr_pick(input logic [NCH-1:0] r, input int ptr);
        for (int k = 0; k < NCH; k++) begin
            if (r[(ptr + k) % NCH]) return (ptr + k) % NCH;
        end
        return -1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 grant_vld after reset", g_vld, 0);
        chk("R1 active after reset", act, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed fixed-mode preemption chain: prio ch0=1 ch1=0 ch2=2 ch3=3
        prio = 8'hE1; pre_en = 4'b0001; rr = 1'b0;
        req = 4'b0001; step();
        chk("R2 grant ch0 alone", g_ch, 0);
        chk("R10 grant_vld", g_vld, 1);
        req = 4'b0101; step();
        chk("R5 preempt grant", g_ch, 2);
        chk("R5 two active", act, 4'b0101);
        req = 4'b1101; step();
        chk("R7 no nesting grant", g_ch, 2);
        chk("R7 active", act, 4'b0101);
        req = 4'b1001; done = 1'b1; fin = 4'b0100; step();
        chk("R6 resume grant", g_ch, 0);
        chk("R9 preemptor cleared", act, 4'b0001);
        done = 1'b0; fin = '0; step();
        chk("R5 second preempt", g_ch, 3);
        chk("R5 second active", act, 4'b1001);
        req = 4'b0001; done = 1'b1; fin = 4'b1000; step();
        chk("R6 resume again", g_ch, 0);
        fin = 4'b0000; req = 4'b0010; step();
        chk("R9 non-final grant ch1", g_ch, 1);
        chk("R9 non-final keeps active", act, 4'b0011);
        fin = 4'b0010; req = '0; step();
        chk("R4 idle", g_vld, 0);
        chk("R9 ch0 still active", act, 4'b0001);
        fin = 4'b0001; step();
        chk("R4 done while idle ignored", act, 4'b0001);
        done = 1'b0; fin = '0; req = 4'b0001; step();
        req = '0; done = 1'b1; fin = 4'b0001; step();
        chk("R9 final clears", act, 0);
        done = 1'b0; fin = '0;

        // Permission bit cleared: no preemption
        pre_en = 4'b0000; req = 4'b0001; step();
        req = 4'b0101; step();
        chk("R8 locked channel keeps grant", g_ch, 0);
        req = 4'b0100; done = 1'b1; fin = 4'b0001; step();
        chk("R2 next after done", g_ch, 2);
        req = '0; fin = 4'b0100; step();
        done = 1'b0; fin = '0;

        // Lower-priority request mid-iteration
        pre_en = 4'b0100; req = 4'b0100; step();
        req = 4'b0101; step();
        chk("R4 lower request no change", g_ch, 2);
        req = 4'b0001; done = 1'b1; fin = 4'b0100; step();
        chk("R4 arbitrate at done", g_ch, 0);
        req = '0; fin = 4'b0001; step();
        done = 1'b0; fin = '0;

        // Round-robin with preemption permission set
        rr = 1'b1; pre_en = 4'b0001; req = 4'b0001; step();
        chk("R3 rr grant ch0", g_ch, 0);
        req = 4'b0101; step();
        chk("R8 rr no preempt", g_ch, 0);
        done = 1'b1; fin = 4'b0001; step();
        chk("R3 rr rotates to ch2", g_ch, 2);
        req = '0; fin = 4'b0100; step();
        done = 1'b0; fin = '0;
        rr_ptr = 3;
        pre_en = '0;

        // Exhaustive sweeps over request patterns and priority assignments
        for (int m = 0; m < 2; m++) begin
            rr = m[0];
            for (int p = 0; p < 256; p++) begin
                for (int r = 1; r < 16; r++) begin
                    int e;
                    prio = p[7:0]; req = r[3:0]; step();
                    if (m == 0) begin
                        e = fixed_pick(r[3:0], p[7:0]);
                        chk("R2 fixed sweep grant", g_ch, e);
                    end else begin
                        e = rr_pick(r[3:0], rr_ptr);
                        rr_ptr = (e + 1) % NCH;
                        chk("R3 rr sweep grant", g_ch, e);
                    end
                    chk("R9 sweep active", act, 1 << e);
                    req = '0; done = 1'b1; fin = 4'b1111; step();
                    done = 1'b0; fin = '0;
                    chk("R9 sweep idle", {g_vld, act}, 0);
                end
            end
        end
        finish_run();
    end
endmodule